// File: doc/BRIEF.md
# Supply Start-Up and Dip Supervisor

This block watches four asynchronous flags from analog comparators and the probe loop: supply above the operating threshold, supply collapsed to the deep threshold, probe oscillating properly, and demagnetization cycle running. From these it derives an internal reset for the rest of the sensor logic, a start-up-complete indication, and a combined active-low error output that stays low whenever the sensor output must not be trusted.

On power-up, the internal reset is held until the supply has been good for a minimum number of cycles. A fixed start-up delay follows before normal operation is declared. Supply disturbances are graded by depth and length. A deep collapse resets at once. A long dip resets. A short dip is forgiven only while the probe keeps oscillating, and a probe failure inside a dip that has already outlasted the glitch window forces a full restart. All flags pass through synchronizer chains, and every duration is a parameter in clock cycles.

Top module: `pwr_supervisor`

## Requirements
- R1: While `arst_n` is low and on its release, `core_rst` is 1, `ready` is 0 and `err_n` is 0.
- R2: `core_rst` falls exactly SYNC_STAGES + HOLD_CYC rising edges after the first edge at which `sup_ok_a` is 1 and `sup_deep_a` is 0, provided both hold steady. This applies at power-up and after any supply-caused reset.
- R3: `ready` rises exactly START_CYC rising edges after `core_rst` falls, unless a reset event intervenes.
- R4: A dip of `sup_ok_a` to 0 lasting fewer than DIP_CYC cycles, with `probe_ok_a` at 1 throughout, leaves `core_rst` at 0, `ready` at 1 and `err_n` at 1 at every cycle.
- R5: A dip of `sup_ok_a` to 0 lasting DIP_CYC cycles or more forces `core_rst` to 1.
- R6: `sup_deep_a` at 1 for even a single cycle forces `core_rst` to 1, whatever the dip length.
- R7: When `sup_ok_a` and `probe_ok_a` drop together for L cycles, `core_rst` rises if L is at least GLITCH_CYC and stays 0 if L is smaller. The glitch window is shorter than the dip window.
- R8: Each reset holds `core_rst` at 1 for at least HOLD_CYC cycles. When the supply is already good, it is exactly HOLD_CYC cycles.
- R9: `err_n` is 1 exactly when `ready` is 1, the demag flag is 0 and the probe flag is 1, counting synchronizer delay. A demag cycle or probe loss with the supply good never causes a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| arst_n | input | 1 | Asynchronous chip reset, active low |
| sup_ok_a | input | 1 | Async flag: supply above operating threshold |
| sup_deep_a | input | 1 | Async flag: supply at or below deep-collapse threshold |
| probe_ok_a | input | 1 | Async flag: probe loop oscillating correctly |
| demag_busy_a | input | 1 | Async flag: demagnetization cycle in progress |
| core_rst | output | 1 | Internal reset for downstream logic, active high |
| ready | output | 1 | Start-up delay has elapsed and the block is in normal operation |
| err_n | output | 1 | Combined error/not-ready indication, active low |

## Verification
If the dip counter is mis-cleared or mis-compared, the fault shows up within one dip of the window length. `core_rst` then either rises for a dip one cycle shorter than DIP_CYC or GLITCH_CYC, or fails to rise for one that reaches it. For that reason the dip length is swept cycle by cycle across both windows. An error in the sequencing counter shifts the fall of `core_rst` or the rise of `ready` by whole cycles against the arithmetic SYNC_STAGES + HOLD_CYC and START_CYC. Those edges are measured exactly. A wrong error-combine term appears as a count of low `err_n` cycles that differs from the stimulus length during demag or probe-loss bursts.

// File: rtl/psv_pkg.sv
package psv_pkg;

   typedef enum logic [1:0] {
      PS_RESET = 2'd0,
      PS_START = 2'd1,
      PS_RUN   = 2'd2
   } psv_state_e;

   // counter width able to hold values 0 .. n-1 (at least one bit)
   function automatic int cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/psv_sync.sv
module psv_sync #(
   parameter int              STAGES  = 2,
   parameter int              W       = 4,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] in_async,
   output logic [W-1:0] out_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("psv_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[s] <= RST_VAL;
            else         chain[s] <= in_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[s] <= RST_VAL;
            else         chain[s] <= chain[s-1];
         end
      end
   end

   assign out_sync = chain[STAGES-1];

endmodule

// File: rtl/psv_dipwatch.sv
module psv_dipwatch #(
   parameter int GLITCH_CYC = 4,
   parameter int DIP_CYC    = 12
) (
   input  logic clk,
   input  logic arst_n,
   input  logic in_reset,
   input  logic sup_ok,
   input  logic sup_deep,
   input  logic probe_ok,
   output logic rst_evt
);

   localparam int             DW          = psv_pkg::cnt_w(DIP_CYC);
   localparam logic [DW-1:0]  DIP_LAST    = DW'(DIP_CYC - 1);
   localparam logic [DW-1:0]  GLITCH_LAST = DW'(GLITCH_CYC - 1);

   if (GLITCH_CYC < 1 || GLITCH_CYC >= DIP_CYC) begin : g_bad_windows
      $error("psv_dipwatch: need 1 <= GLITCH_CYC < DIP_CYC");
   end

   logic [DW-1:0] dip_len;
   logic          long_dip, probe_lost;

   // consecutive cycles the supply flag has been low, saturating
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                   dip_len <= '0;
      else if (in_reset || sup_ok)   dip_len <= '0;
      else if (dip_len != DIP_LAST)  dip_len <= dip_len + 1'b1;
   end

   assign long_dip   = !sup_ok && (dip_len == DIP_LAST);
   assign probe_lost = !sup_ok && !probe_ok && (dip_len >= GLITCH_LAST);
   assign rst_evt    = !in_reset && (sup_deep || long_dip || probe_lost);

   // R5: the dip length counter never runs past its window
   a_r5_dip_bound : assert property (@(posedge clk) disable iff (!arst_n)
      dip_len <= DIP_LAST);

   // R4: a dip counter already running implies the supply flag was low last cycle
   a_r4_count_src : assert property (@(posedge clk) disable iff (!arst_n)
      (dip_len != '0) |-> !$past(sup_ok));

endmodule

// File: rtl/psv_seq.sv
module psv_seq #(
   parameter int HOLD_CYC  = 3,
   parameter int START_CYC = 6
) (
   input  logic clk,
   input  logic arst_n,
   input  logic sup_ok,
   input  logic sup_deep,
   input  logic rst_evt,
   output logic core_rst,
   output logic ready
);
   import psv_pkg::*;

   localparam int             MAXC       = (HOLD_CYC > START_CYC) ? HOLD_CYC : START_CYC;
   localparam int             TW         = cnt_w(MAXC);
   localparam logic [TW-1:0]  HOLD_LAST  = TW'(HOLD_CYC - 1);
   localparam logic [TW-1:0]  START_LAST = TW'(START_CYC - 1);

   if (HOLD_CYC < 1 || START_CYC < 1) begin : g_bad_times
      $error("psv_seq: HOLD_CYC and START_CYC must be at least 1");
   end

   psv_state_e    state_q, state_d;
   logic [TW-1:0] tcnt_q, tcnt_d;
   logic          supply_good;

   assign supply_good = sup_ok && !sup_deep;

   always_comb begin
      state_d = state_q;
      tcnt_d  = tcnt_q;
      unique case (state_q)
         PS_RESET: begin
            if (!supply_good) begin
               tcnt_d = '0;
            end else if (tcnt_q == HOLD_LAST) begin
               state_d = PS_START;
               tcnt_d  = '0;
            end else begin
               tcnt_d = tcnt_q + 1'b1;
            end
         end
         PS_START: begin
            if (rst_evt) begin
               state_d = PS_RESET;
               tcnt_d  = '0;
            end else if (tcnt_q == START_LAST) begin
               state_d = PS_RUN;
               tcnt_d  = '0;
            end else begin
               tcnt_d = tcnt_q + 1'b1;
            end
         end
         default: begin
            if (rst_evt) begin
               state_d = PS_RESET;
               tcnt_d  = '0;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q <= PS_RESET;
         tcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         tcnt_q  <= tcnt_d;
      end
   end

   assign core_rst = (state_q == PS_RESET);
   assign ready    = (state_q == PS_RUN);

   // checker-side run length of the reset output
   localparam int RW = cnt_w(HOLD_CYC + 2);
   logic [RW-1:0] rst_run_q;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                          rst_run_q <= '0;
      else if (!core_rst)                   rst_run_q <= '0;
      else if (rst_run_q < RW'(HOLD_CYC))   rst_run_q <= rst_run_q + 1'b1;
   end

   // R8: reset is never released before its minimum hold
   a_r8_hold_min : assert property (@(posedge clk) disable iff (!arst_n)
      $fell(core_rst) |-> (rst_run_q >= RW'(HOLD_CYC)));

   // R5: a reset event from the dip watcher always lands in reset
   a_r5_evt_resets : assert property (@(posedge clk) disable iff (!arst_n)
      rst_evt |=> core_rst);

   // R2: reset only releases on a good supply
   a_r2_release_good : assert property (@(posedge clk) disable iff (!arst_n)
      $fell(core_rst) |-> $past(sup_ok && !sup_deep));

   // R3: ready never follows reset directly
   a_r3_no_skip : assert property (@(posedge clk) disable iff (!arst_n)
      $rose(ready) |-> $past(!core_rst));

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
   parameter int SYNC_STAGES = 2,
   parameter int GLITCH_CYC  = 6200,
   parameter int DIP_CYC     = 20000,
   parameter int START_CYC   = 6400,
   parameter int HOLD_CYC    = 16,
   parameter bit ERR_REG     = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic sup_ok_a,
   input  logic sup_deep_a,
   input  logic probe_ok_a,
   input  logic demag_busy_a,
   output logic core_rst,
   output logic ready,
   output logic err_n
);

   localparam int           NFLAG    = 4;
   // bit order: demag, probe, deep, supply ; reset to the unsafe value
   localparam logic [3:0]   FLAG_RST = 4'b1010;

   logic [NFLAG-1:0] flags_a, flags_s;
   logic             s_sup, s_deep, s_probe, s_demag;
   logic             rst_evt, err_n_d;

   assign flags_a = {demag_busy_a, probe_ok_a, sup_deep_a, sup_ok_a};

   psv_sync #(.STAGES(SYNC_STAGES), .W(NFLAG), .RST_VAL(FLAG_RST)) i_sync (
      .clk      (clk),
      .arst_n   (arst_n),
      .in_async (flags_a),
      .out_sync (flags_s)
   );

   assign {s_demag, s_probe, s_deep, s_sup} = flags_s;

   psv_dipwatch #(.GLITCH_CYC(GLITCH_CYC), .DIP_CYC(DIP_CYC)) i_dip (
      .clk      (clk),
      .arst_n   (arst_n),
      .in_reset (core_rst),
      .sup_ok   (s_sup),
      .sup_deep (s_deep),
      .probe_ok (s_probe),
      .rst_evt  (rst_evt)
   );

   psv_seq #(.HOLD_CYC(HOLD_CYC), .START_CYC(START_CYC)) i_seq (
      .clk      (clk),
      .arst_n   (arst_n),
      .sup_ok   (s_sup),
      .sup_deep (s_deep),
      .rst_evt  (rst_evt),
      .core_rst (core_rst),
      .ready    (ready)
   );

   assign err_n_d = ready && !s_demag && s_probe;

   if (ERR_REG) begin : g_err_reg
      logic err_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) err_q <= 1'b0;
         else         err_q <= err_n_d;
      end
      assign err_n = err_q;

      // R9: demag activity pulls the error output low one cycle later
      a_r9_demag_err : assert property (@(posedge clk) disable iff (!arst_n)
         s_demag |=> !err_n);
   end else begin : g_err_comb
      assign err_n = err_n_d;

      // R9: demag activity pulls the error output low at once
      a_r9_demag_err : assert property (@(posedge clk) disable iff (!arst_n)
         s_demag |-> !err_n);
   end

   // R1: while in reset the error output is never high
   a_r1_err_in_reset : assert property (@(posedge clk) disable iff (!arst_n)
      (core_rst && $past(core_rst)) |-> !err_n);

   // R6: deep collapse outside reset forces reset on the next cycle
   a_r6_deep_resets : assert property (@(posedge clk) disable iff (!arst_n)
      (s_deep && !core_rst) |=> core_rst);

   // R9: demag or probe loss with good supply does not cause reset
   a_r9_no_reset : assert property (@(posedge clk) disable iff (!arst_n)
      (ready && s_sup && !s_deep) |=> !core_rst);

endmodule

// File: tb/test_pwr_supervisor.sv
`timescale 1ns/1ps
module test_pwr_supervisor;

   localparam int SYNC   = 2;
   localparam int GLITCH = 4;
   localparam int DIP    = 12;
   localparam int START  = 6;
   localparam int HOLD   = 3;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic sup_ok_a = 1'b0, sup_deep_a = 1'b1, probe_ok_a = 1'b0, demag_busy_a = 1'b0;
   logic core_rst, ready, err_n;

   int n_vec = 0;
   int n_bad = 0;
   int cyc   = 0;
   int c_rst = 0, c_nrdy = 0, c_errl = 0;

   always #2.5 clk = ~clk;

   pwr_supervisor #(
      .SYNC_STAGES(SYNC), .GLITCH_CYC(GLITCH), .DIP_CYC(DIP),
      .START_CYC(START), .HOLD_CYC(HOLD), .ERR_REG(1'b0)
   ) i_pwr_supervisor (
      .clk(clk), .arst_n(arst_n), .sup_ok_a(sup_ok_a), .sup_deep_a(sup_deep_a),
      .probe_ok_a(probe_ok_a), .demag_busy_a(demag_busy_a),
      .core_rst(core_rst), .ready(ready), .err_n(err_n)
   );

   // sample monitors away from the active edge
   always @(negedge clk) begin
      if (core_rst) c_rst++;
      if (!ready)   c_nrdy++;
      if (!err_n)   c_errl++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clr_mon();
      c_rst = 0; c_nrdy = 0; c_errl = 0;
   endtask

   // count rising edges until signal reaches value (sampled 1 ns after edge)
   task automatic edges_until_rst_low(output int n);
      n = 0;
      do begin
         @(posedge clk); #1; n++;
      end while (core_rst && n < 1000);
   endtask

   task automatic edges_until_ready(output int n);
      n = 0;
      do begin
         @(posedge clk); #1; n++;
      end while (!ready && n < 1000);
   endtask

   task automatic recover();
      int n;
      edges_until_ready(n);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int n;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 core_rst", core_rst, 1);
      check("R1 ready", ready, 0);
      check("R1 err_n", err_n, 0);

      sup_ok_a = 1'b1; sup_deep_a = 1'b0; probe_ok_a = 1'b1;
      arst_n = 1'b1;
      check("R1 core_rst after release", core_rst, 1);
      edges_until_rst_low(n);
      check("R2 power-up reset length", n, SYNC + HOLD);
      edges_until_ready(n);
      check("R3 start-up delay", n, START);
      #1;
      check("R9 err_n high in run", err_n, 1);

      // R4/R5: supply-only dip length sweep
      for (int len = 1; len <= DIP + 2; len++) begin
         @(negedge clk); clr_mon();
         sup_ok_a = 1'b0;
         repeat (len) @(negedge clk);
         sup_ok_a = 1'b1;
         repeat (SYNC + 3) @(negedge clk);
         if (len < DIP) begin
            check("R4 short dip no reset", c_rst, 0);
            check("R4 short dip err_n stays high", c_errl, 0);
            check("R4 short dip ready stays", c_nrdy, 0);
         end else begin
            check("R5 long dip resets", (c_rst > 0) ? 1 : 0, 1);
            recover();
         end
      end

      // R7: supply and probe drop together
      for (int len = 1; len <= GLITCH + 2; len++) begin
         @(negedge clk); clr_mon();
         sup_ok_a = 1'b0; probe_ok_a = 1'b0;
         repeat (len) @(negedge clk);
         sup_ok_a = 1'b1; probe_ok_a = 1'b1;
         repeat (SYNC + 3) @(negedge clk);
         if (len < GLITCH) begin
            check("R7 probe glitch no reset", c_rst, 0);
            check("R9 err_n low for probe loss", c_errl, len);
         end else begin
            check("R7 probe lost in dip resets", (c_rst > 0) ? 1 : 0, 1);
            recover();
         end
      end

      // R6/R8: single-cycle deep collapse, supply flag stays good
      @(negedge clk); clr_mon();
      sup_deep_a = 1'b1;
      @(negedge clk);
      sup_deep_a = 1'b0;
      repeat (SYNC + HOLD + START + 4) @(negedge clk);
      check("R6 deep pulse resets", (c_rst > 0) ? 1 : 0, 1);
      check("R8 hold length", c_rst, HOLD);
      check("R3 not-ready length after deep", c_nrdy, HOLD + START);

      // R2/R5: long outage, then measured release from restore
      @(negedge clk);
      sup_ok_a = 1'b0;
      repeat (3 * DIP) @(negedge clk);
      check("R5 long outage in reset", core_rst, 1);
      sup_ok_a = 1'b1;
      edges_until_rst_low(n);
      check("R2 release after restore", n, SYNC + HOLD);
      edges_until_ready(n);
      check("R3 start after restore", n, START);

      // R9: demag burst in run
      for (int k = 1; k <= 6; k += 5) begin
         @(negedge clk); clr_mon();
         demag_busy_a = 1'b1;
         repeat (k) @(negedge clk);
         demag_busy_a = 1'b0;
         repeat (SYNC + 3) @(negedge clk);
         check("R9 demag err_n low count", c_errl, k);
         check("R9 demag no reset", c_rst, 0);
      end

      // R9: probe loss with good supply
      @(negedge clk); clr_mon();
      probe_ok_a = 1'b0;
      repeat (20) @(negedge clk);
      probe_ok_a = 1'b1;
      repeat (SYNC + 3) @(negedge clk);
      check("R9 probe loss err_n count", c_errl, 20);
      check("R9 probe loss no reset", c_rst, 0);
      check("R9 probe loss ready kept", c_nrdy, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule